// File: doc/BRIEF.md
# Hub-Synchronised SDRAM Window Scheduler

This block sits between a round-robin shared-memory hub and a single-data-rate SDRAM whose clock runs at twice the hub rate. It cuts SDRAM time into fixed windows of 32 clocks, one window per hub rotation, and every window begins on the hub slot boundary. In each window it first serves the processor core that owns the current hub slot. That access is one or two sequential 32-bit longs, read or written. The block then starts a full-page read burst of up to 16 words for a video controller and ends that burst early with a PRECHARGE, so that the next window's core access starts on time.

Refresh is never allowed to disturb active video. A pending-refresh count grows at a fixed rate. While the blanking input is high, one AUTO REFRESH per window takes the place of the video burst until the count is back at zero. Each long occupies two adjacent 16-bit columns, low half first, and CAS latency is two clocks. The block drives SDRAM command, bank, address and data pins itself and samples the returning data bus.

Top module: `sdram_slot_sched`

## Requirements
- R1: During reset and for the whole first window after reset release the command is NOP. Commands are encoded on sd_cmd as {cs_n,ras_n,cas_n,we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001. Phase 0 is the first clock after reset release, and slot_start is high in phase 0 of every 32-clock window and low otherwise.
- R2: A core request is sampled on the edge into phase 0. In that case ACTIVE is issued in phase 0 with bank = core_addr[20:19] and row = core_addr[18:7]. READ or WRITE follows in phase 2 with sd_a = {core_addr[6:0],1'b0} zero-extended. PRECHARGE with sd_a[10]=1 follows in phase 2+2n, where n is 1 (core_two low) or 2 (core_two high).
- R3: For a core write, sd_dq_oe is high in phases 2 to 1+2n and low everywhere else. In phase 2+k, sd_dq_out carries core_wdata[16k+15:16k].
- R4: For a core read, sd_dq_in is sampled in phases 4 to 3+2n. core_done is high only in phase 4+2n. In that phase core_rdata bits [16k+15:16k] hold the word sampled in phase 4+k. For a single-long read, core_rdata[63:32] is zero.
- R5: In a window without a core request, phases 0 to 9 carry only NOP, and the video and refresh timing is unchanged.
- R6: The video inputs are sampled on the edge into phase 10. With L = min(vid_len,16) and L nonzero, ACTIVE is issued in phase 10 with bank = vid_addr[21:20] and row = vid_addr[19:8]. READ follows in phase 12 with sd_a = vid_addr[7:0], and PRECHARGE with sd_a[10]=1 follows in phase 12+L. A vid_len of 0 issues no burst.
- R7: vid_valid is high exactly in phases 15 to 14+L. In phase 15+k, vid_data equals the sd_dq_in word of phase 14+k.
- R8: The pending-refresh count rises by one in each window whose index modulo 4 equals 3 (the reset window has index 0) and saturates at 8. No AUTO REFRESH is issued while blank is low on the phase-10 edge.
- R9: When blank is high on the edge into phase 10 and the count is nonzero, AUTO REFRESH is issued in phase 10 instead of the video ACTIVE, no video burst follows, and the count falls by one. At most one refresh is issued per window.
- R10: In a window where the count would rise and a refresh is issued, the count is left unchanged.
- R11: A change of core_req away from the phase-0 sampling edge has no effect on the commands of that window or of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock, twice the hub clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 1 | Slot owner requests an access this window |
| core_we | input | 1 | 1 = write, 0 = read |
| core_two | input | 1 | 1 = two sequential longs, 0 = one long |
| core_addr | input | 21 | Long address {bank, row, long column} |
| core_wdata | input | 64 | Write data, first long in bits 31:0 |
| core_rdata | output | 64 | Read data, first long in bits 31:0 |
| core_done | output | 1 | One-cycle completion pulse |
| vid_req | input | 1 | Video burst wanted this window |
| vid_addr | input | 22 | Start word address {bank, row, column} |
| vid_len | input | 5 | Burst length in words, clamped to 16 |
| vid_data | output | 16 | Streamed video word |
| vid_valid | output | 1 | vid_data strobe |
| blank | input | 1 | High during video blanking; refresh permitted |
| slot_start | output | 1 | High in phase 0 of each window |
| sd_cmd | output | 4 | {cs_n,ras_n,cas_n,we_n} |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 12 | Row / column address |
| sd_dq_out | output | 16 | Write data to SDRAM |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 16 | Read data from SDRAM |

## Verification
Two functions share the phase-10 decision and can act on the same edge. The refresh accrual tick can coincide with a refresh being issued, and a refresh can displace a video burst that is requested in the same window. The bench holds blanking low long enough to saturate the pending count. It then raises blanking for a run of windows in which video is always requested, so that ticks land in windows that also drain a refresh. A model counter kept in the bench predicts for each window whether phase 10 carries AUTO REFRESH or a video ACTIVE. The full command stream is compared phase by phase against that prediction.

// File: rtl/sdsched_pkg.sv
// Shared command encoding for the SDRAM window scheduler.
// Assumes the usual four-wire SDR command bus {cs_n,ras_n,cas_n,we_n}.
package sdsched_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001
    } sd_cmd_e;

endpackage

// File: rtl/sdsched_phase.sv
// Window phase counter: counts SDRAM clocks inside one hub rotation.
// Assumes WIN is the number of SDRAM clocks per hub rotation and that
// reset deasserts on a hub slot boundary, so phase 0 follows reset.
module sdsched_phase #(
    parameter int WIN = 32,
    parameter int PW  = $clog2(WIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] cnt,
    output logic [PW-1:0] nxt,
    output logic          slot_start
);

    // phase that the next edge moves into
    assign nxt = (cnt == PW'(WIN - 1)) ? '0 : cnt + 1'b1;

    // advance the phase, wrapping at the window length
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= nxt;
    end

    assign slot_start = (cnt == '0);

    // R1
    slot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |=> !slot_start);

endmodule

// File: rtl/sdsched_refresh.sv
// Pending-refresh bookkeeping: accrues one refresh every REF_WINDOWS
// windows, saturating at REF_MAX, and grants one refresh per window
// while blanking is high. Assumes upd pulses once per window, on the
// edge where the refresh/video decision is taken.
module sdsched_refresh #(
    parameter int REF_WINDOWS = 4,
    parameter int REF_MAX     = 8,
    parameter int CW          = $clog2(REF_MAX + 1),
    parameter int WW          = $clog2(REF_WINDOWS) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic blank,
    output logic ref_now
);

    logic [CW-1:0] pend, pend_n;
    logic [WW-1:0] wcnt;
    logic          tick;

    assign tick    = (wcnt == WW'(REF_WINDOWS - 1));
    assign ref_now = blank && (pend != '0);

    // next pending count: add on tick, remove on grant, clamp at max
    always_comb begin
        unique case ({tick, ref_now})
            2'b10:   pend_n = (pend == CW'(REF_MAX)) ? pend : pend + 1'b1;
            2'b01:   pend_n = pend - 1'b1;
            default: pend_n = pend;
        endcase
    end

    // update count and window divider once per window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            wcnt <= '0;
        end else if (upd) begin
            pend <= pend_n;
            wcnt <= tick ? '0 : wcnt + 1'b1;
        end
    end

    // R8
    pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= CW'(REF_MAX));

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(pend));

    // R10
    pend_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && tick && ref_now) |=> $stable(pend));

endmodule

// File: rtl/sdsched_capture.sv
// Read-data capture: collects the core's 16-bit halves into longs with a
// completion pulse, and re-registers video burst words with a strobe.
// Assumes data appears CL clocks after each READ command and that the
// command phases are CCMD (core) and VRD (video) within the window.
module sdsched_capture #(
    parameter int DQ_W = 16,
    parameter int CL   = 2,
    parameter int CCMD = 2,
    parameter int VRD  = 12,
    parameter int LW   = 5,
    parameter int PW   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     cnt,
    input  logic [DQ_W-1:0]   dq_in,
    input  logic              clr,
    input  logic              core_rd,
    input  logic [2:0]        core_h,
    input  logic              vid_go,
    input  logic [LW-1:0]     vlen,
    output logic [4*DQ_W-1:0] core_rdata,
    output logic              core_done,
    output logic [DQ_W-1:0]   vid_data,
    output logic              vid_valid
);

    int ph, h, vl;

    // integer views of phase and lengths for window arithmetic
    always_comb begin
        ph = int'(cnt);
        h  = int'(core_h);
        vl = int'(vlen);
    end

    for (genvar k = 0; k < 4; k++) begin : g_word
        logic [DQ_W-1:0] word_q;

        // capture half k of the core transfer in its data phase
        always_ff @(posedge clk) begin
            if (!rst_n)      word_q <= '0;
            else if (clr)    word_q <= '0;
            else if (core_rd && (ph == CCMD + CL + k) && (k < h))
                             word_q <= dq_in;
        end

        assign core_rdata[k*DQ_W +: DQ_W] = word_q;
    end

    // completion pulse in the phase after the last core half
    always_ff @(posedge clk) begin
        if (!rst_n) core_done <= 1'b0;
        else        core_done <= core_rd && (ph == CCMD + CL + h - 1);
    end

    // register each video word with its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_valid <= 1'b0;
            vid_data  <= '0;
        end else begin
            vid_valid <= vid_go && (ph >= VRD + CL) && (ph < VRD + CL + vl);
            vid_data  <= dq_in;
        end
    end

    // R4
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> !core_done);

    // R7
    valid_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid |-> !core_done);

endmodule

// File: rtl/sdram_slot_sched.sv
// Hub-synchronised SDRAM scheduler. Each WIN-clock window serves the core
// that owns the hub slot (1 or 2 longs) first, then either one AUTO
// REFRESH (blanking, refresh owed) or a video full-page read burst cut
// short by PRECHARGE. Assumes the SDRAM is initialised, in full-page
// burst mode, with CAS latency CL and all banks idle at phase 0.
module sdram_slot_sched #(
    parameter int WIN         = 32,
    parameter int BA_W        = 2,
    parameter int ROW_W       = 12,
    parameter int COL_W       = 8,
    parameter int DQ_W        = 16,
    parameter int CL          = 2,
    parameter int TRCD        = 2,
    parameter int VID_START   = 10,
    parameter int VID_MAX     = 16,
    parameter int REF_WINDOWS = 4,
    parameter int REF_MAX     = 8,
    localparam int CAW        = BA_W + ROW_W + COL_W - 1,
    localparam int VAW        = BA_W + ROW_W + COL_W,
    localparam int LW         = $clog2(VID_MAX) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic              core_two,
    input  logic [CAW-1:0]    core_addr,
    input  logic [4*DQ_W-1:0] core_wdata,
    output logic [4*DQ_W-1:0] core_rdata,
    output logic              core_done,
    input  logic              vid_req,
    input  logic [VAW-1:0]    vid_addr,
    input  logic [LW-1:0]     vid_len,
    output logic [DQ_W-1:0]   vid_data,
    output logic              vid_valid,
    input  logic              blank,
    output logic              slot_start,
    output logic [3:0]        sd_cmd,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ROW_W-1:0]  sd_a,
    output logic [DQ_W-1:0]   sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DQ_W-1:0]   sd_dq_in
);
    import sdsched_pkg::*;

    localparam int PW   = $clog2(WIN);
    localparam int CCMD = TRCD;
    localparam int VRD  = VID_START + TRCD;
    localparam int AP   = 10;

    logic [PW-1:0] cnt, nxt;
    logic          upd, ref_now, vid_ok, clr;
    logic [LW-1:0] vlen_eff, vlen_q;

    logic                core_go, core_we_q, core_two_q;
    logic [CAW-1:0]      c_addr_q;
    logic [4*DQ_W-1:0]   c_wdata_q;
    logic                vid_go;
    logic [VAW-1:0]      v_addr_q;
    logic [2:0]          core_h;
    int                  nx, h_i;

    sd_cmd_e             cmd_q, cmd_n;
    logic [BA_W-1:0]     ba_n;
    logic [ROW_W-1:0]    a_n;
    logic [1:0]          wsel;

    sdsched_phase #(.WIN(WIN), .PW(PW)) phase_i (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .nxt(nxt), .slot_start(slot_start));

    assign upd = (nxt == PW'(VID_START));

    sdsched_refresh #(.REF_WINDOWS(REF_WINDOWS), .REF_MAX(REF_MAX)) refresh_i (
        .clk(clk), .rst_n(rst_n), .upd(upd), .blank(blank), .ref_now(ref_now));

    // clamp the burst length and decide whether video runs this window
    always_comb begin
        vlen_eff = (vid_len > LW'(VID_MAX)) ? LW'(VID_MAX) : vid_len;
        vid_ok   = vid_req && (vlen_eff != '0) && !ref_now;
        core_h   = core_two_q ? 3'd4 : 3'd2;
        h_i      = int'(core_h);
        nx       = int'(nxt);
        clr      = (nxt == '0) && core_req && !core_we;
    end

    // latch the core request at the slot boundary, video at its offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_go    <= 1'b0;
            core_we_q  <= 1'b0;
            core_two_q <= 1'b0;
            c_addr_q   <= '0;
            c_wdata_q  <= '0;
            vid_go     <= 1'b0;
            v_addr_q   <= '0;
            vlen_q     <= '0;
        end else begin
            if (nxt == '0) begin
                core_go    <= core_req;
                core_we_q  <= core_we;
                core_two_q <= core_two;
                c_addr_q   <= core_addr;
                c_wdata_q  <= core_wdata;
            end
            if (upd) begin
                vid_go   <= vid_ok;
                v_addr_q <= vid_addr;
                vlen_q   <= vlen_eff;
            end
        end
    end

    // choose the command for the phase being entered
    always_comb begin
        cmd_n = CMD_NOP;
        ba_n  = '0;
        a_n   = '0;
        if (nx == 0 && core_req) begin
            cmd_n = CMD_ACT;
            ba_n  = core_addr[CAW-1 -: BA_W];
            a_n   = core_addr[COL_W-1 +: ROW_W];
        end else if (core_go && nx == CCMD) begin
            cmd_n = core_we_q ? CMD_WR : CMD_RD;
            ba_n  = c_addr_q[CAW-1 -: BA_W];
            a_n   = ROW_W'({c_addr_q[COL_W-2:0], 1'b0});
        end else if (core_go && nx == CCMD + h_i) begin
            cmd_n   = CMD_PRE;
            a_n[AP] = 1'b1;
        end else if (nx == VID_START && ref_now) begin
            cmd_n = CMD_REF;
        end else if (nx == VID_START && vid_ok) begin
            cmd_n = CMD_ACT;
            ba_n  = vid_addr[VAW-1 -: BA_W];
            a_n   = vid_addr[COL_W +: ROW_W];
        end else if (vid_go && nx == VRD) begin
            cmd_n = CMD_RD;
            ba_n  = v_addr_q[VAW-1 -: BA_W];
            a_n   = ROW_W'(v_addr_q[COL_W-1:0]);
        end else if (vid_go && nx == VRD + int'(vlen_q)) begin
            cmd_n   = CMD_PRE;
            a_n[AP] = 1'b1;
        end
    end

    // register the command bus so every pin leaves from a flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_NOP;
            sd_ba <= '0;
            sd_a  <= '0;
        end else begin
            cmd_q <= cmd_n;
            sd_ba <= ba_n;
            sd_a  <= a_n;
        end
    end

    assign sd_cmd = cmd_q;
    assign wsel   = 2'(nx - CCMD);

    // drive write halves in the write-burst phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_dq_oe  <= 1'b0;
            sd_dq_out <= '0;
        end else begin
            sd_dq_oe  <= core_go && core_we_q && (nx >= CCMD) && (nx < CCMD + h_i);
            sd_dq_out <= c_wdata_q[int'(wsel)*DQ_W +: DQ_W];
        end
    end

    sdsched_capture #(.DQ_W(DQ_W), .CL(CL), .CCMD(CCMD), .VRD(VRD),
                      .LW(LW), .PW(PW)) capture_i (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .dq_in(sd_dq_in), .clr(clr),
        .core_rd(core_go && !core_we_q), .core_h(core_h),
        .vid_go(vid_go), .vlen(vlen_q),
        .core_rdata(core_rdata), .core_done(core_done),
        .vid_data(vid_data), .vid_valid(vid_valid));

    // R1
    slot_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |-> (cmd_q == CMD_NOP || cmd_q == CMD_ACT));

    // R2
    act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_ACT) |=> (cmd_q == CMD_NOP));

    // R3
    oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (core_go && core_we_q));

    // R9
    ref_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_REF) |-> ($past(blank) && !vid_go));

endmodule

// File: tb/sdram_slot_sched_tb.sv
module sdram_slot_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001;

    logic        clk, rst_n;
    logic        core_req, core_we, core_two;
    logic [20:0] core_addr;
    logic [63:0] core_wdata, core_rdata;
    logic        core_done;
    logic        vid_req;
    logic [21:0] vid_addr;
    logic [4:0]  vid_len;
    logic [15:0] vid_data;
    logic        vid_valid, blank, slot_start;
    logic [3:0]  sd_cmd;
    logic [1:0]  sd_ba;
    logic [11:0] sd_a;
    logic [15:0] sd_dq_out, sd_dq_in;
    logic        sd_dq_oe;

    int checks = 0, fails = 0, pend_m = 0, win_idx = 0;
    bit fin = 0;
    logic [15:0] rec [32];

    sdram_slot_sched dut_i (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
        .core_two(core_two), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_rdata(core_rdata), .core_done(core_done), .vid_req(vid_req),
        .vid_addr(vid_addr), .vid_len(vid_len), .vid_data(vid_data),
        .vid_valid(vid_valid), .blank(blank), .slot_start(slot_start),
        .sd_cmd(sd_cmd), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // one full window: inputs set at phase 31 of the previous window
    task automatic run_window(input bit creq, input bit cwe, input bit ctwo,
                              input logic [20:0] caddr, input logic [63:0] cwd,
                              input bit vreq, input logic [21:0] vaddr,
                              input int vlen, input bit blk, input bit late);
        int h, vl, tick;
        bit cgo, iss, vgo, eo, ed, ev;
        logic [3:0] ec; logic [1:0] eb; logic [11:0] ea;
        logic [63:0] er;
        string tg;
        core_req = late ? 1'b0 : creq; core_we = cwe; core_two = ctwo;
        core_addr = caddr; core_wdata = cwd;
        vid_req = vreq; vid_addr = vaddr; vid_len = 5'(vlen); blank = blk;
        win_idx++;
        cgo  = creq && !late;
        h    = ctwo ? 4 : 2;
        vl   = (vlen > 16) ? 16 : vlen;
        tick = (win_idx % 4 == 3) ? 1 : 0;
        iss  = blk && (pend_m > 0);
        vgo  = vreq && (vl > 0) && !iss;
        for (int p = 0; p < 32; p++) begin
            @(negedge clk);
            if (p == 0) core_req = ~core_req;              // R11 ignored change
            if (late && p == 3)  core_req = 1'b1;
            if (late && p == 20) core_req = 1'b0;
            if (p == 1) core_req = 1'b0;
            ec = C_NOP; eb = '0; ea = '0;
            if (p == 0 && cgo) begin ec = C_ACT; eb = caddr[20:19]; ea = caddr[18:7]; end
            else if (cgo && p == 2) begin ec = cwe ? C_WR : C_RD; eb = caddr[20:19]; ea = {4'b0, caddr[6:0], 1'b0}; end
            else if (cgo && p == 2 + h) begin ec = C_PRE; ea = 12'h400; end
            else if (p == 10 && iss) ec = C_REF;
            else if (p == 10 && vgo) begin ec = C_ACT; eb = vaddr[21:20]; ea = vaddr[19:8]; end
            else if (vgo && p == 12) begin ec = C_RD; eb = vaddr[21:20]; ea = {4'b0, vaddr[7:0]}; end
            else if (vgo && p == 12 + vl) begin ec = C_PRE; ea = 12'h400; end
            if (p < 10) tg = late ? "R11" : (cgo ? "R2" : "R5");
            else tg = iss ? (tick != 0 ? "R10" : "R9") : (vgo ? "R6" : "R8");
            chk(sd_cmd == ec, tg, "cmd", 64'(sd_cmd), 64'(ec));
            if (ec == C_ACT || ec == C_RD || ec == C_WR)
                chk(sd_ba == eb, tg, "bank", 64'(sd_ba), 64'(eb));
            if (ec != C_NOP && ec != C_REF)
                chk(sd_a == ea, tg, "addr", 64'(sd_a), 64'(ea));
            chk(slot_start == (p == 0), "R1", "slot_start", 64'(slot_start), 64'(p == 0));
            eo = cgo && cwe && p >= 2 && p < 2 + h;
            chk(sd_dq_oe == eo, "R3", "dq_oe", 64'(sd_dq_oe), 64'(eo));
            if (eo) chk(sd_dq_out == cwd[(p-2)*16 +: 16], "R3", "dq_out",
                        64'(sd_dq_out), 64'(cwd[(p-2)*16 +: 16]));
            ed = cgo && !cwe && p == 4 + h;
            chk(core_done == ed, "R4", "done", 64'(core_done), 64'(ed));
            if (ed) begin
                er = (h == 4) ? {rec[7], rec[6], rec[5], rec[4]} : {32'b0, rec[5], rec[4]};
                chk(core_rdata == er, "R4", "rdata", core_rdata, er);
            end
            ev = vgo && p >= 15 && p < 15 + vl;
            chk(vid_valid == ev, "R7", "vid_valid", 64'(vid_valid), 64'(ev));
            if (ev) chk(vid_data == rec[p-1], "R7", "vid_data", 64'(vid_data), 64'(rec[p-1]));
            if (p == 10) begin
                pend_m = pend_m + tick - (iss ? 1 : 0);
                if (pend_m > 8) pend_m = 8;
            end
            rec[p] = 16'($urandom);
            sd_dq_in = rec[p];
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; core_req = 0; core_we = 0; core_two = 0; core_addr = '0;
        core_wdata = '0; vid_req = 0; vid_addr = '0; vid_len = '0; blank = 0;
        sd_dq_in = '0;
        repeat (3) @(negedge clk);
        chk(sd_cmd == C_NOP, "R1", "reset cmd", 64'(sd_cmd), 64'(C_NOP));
        chk(sd_dq_oe == 0 && core_done == 0 && vid_valid == 0, "R1", "reset outs",
            64'({sd_dq_oe, core_done, vid_valid}), 64'(0));
        rst_n = 1'b1;
        for (int p = 0; p < 32; p++) begin
            if (p > 0) @(negedge clk);
            chk(sd_cmd == C_NOP, "R1", "first window cmd", 64'(sd_cmd), 64'(C_NOP));
            chk(slot_start == (p == 0), "R1", "slot_start", 64'(slot_start), 64'(p == 0));
            rec[p] = 16'($urandom); sd_dq_in = rec[p];
        end
        // directed corner cases
        run_window(1, 1, 0, 21'h1A_2B3C, 64'h1111_2222_3333_4444, 0, '0, 0, 0, 0);
        run_window(1, 0, 0, 21'h0F_00FF, '0, 1, 22'h2A_5A5A, 16, 0, 0);
        run_window(1, 0, 1, 21'h12_3456, '0, 1, 22'h01_0203, 20, 0, 0);
        run_window(1, 1, 1, 21'h1F_FFFF, 64'hDEAD_BEEF_CAFE_F00D, 1, 22'h3F_FFFF, 1, 0, 0);
        run_window(0, 0, 0, '0, '0, 1, 22'h15_5555, 16, 0, 0);
        run_window(1, 0, 0, 21'h05_0505, '0, 1, 22'h00_0010, 0, 0, 1);
        run_window(0, 0, 0, '0, '0, 0, '0, 0, 0, 0);
        // blanking low: pending count climbs to saturation (R8)
        for (int i = 0; i < 36; i++)
            run_window($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
                       21'($urandom), {$urandom, $urandom}, $urandom_range(0,1),
                       22'($urandom), $urandom_range(0,20), 0, 0);
        // blanking high with video always requested: drain and coincide (R9, R10)
        for (int i = 0; i < 14; i++)
            run_window($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
                       21'($urandom), {$urandom, $urandom}, 1,
                       22'($urandom), $urandom_range(1,16), 1, 0);
        // fully random mix
        for (int i = 0; i < 40; i++)
            run_window($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
                       21'($urandom), {$urandom, $urandom}, $urandom_range(0,1),
                       22'($urandom), $urandom_range(0,20), $urandom_range(0,3) == 0,
                       $urandom_range(0,7) == 0);
        fin = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!fin) begin
            checks++; fails++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule